// File: doc/BRIEF.md
# Packed-Vector Media Arithmetic Unit

This block is a pipelined execution unit for a wide media processor. It treats each 64-bit operand as a packed vector and offers three operations. The first is a sum of absolute differences across eight unsigned bytes, which yields a scalar. The second is a four-lane signed 16-bit multiply that keeps only the rounded high half of each product. The third is an eight-lane byte average of four inputs, as used for two-dimensional half-pixel interpolation.

Each operation is issued with an opcode, the source operands and a predicate bit, under a valid strobe. The unit accepts one operation per cycle. Every accepted operation returns its result a fixed two cycles later, with a result strobe. When the predicate is false, the operation is dropped and the result register keeps its old contents. Register storage, issue and operand forwarding sit outside the block.

Top module: `simd_media_unit`

## Requirements
- R1: While reset is low, and after it is released with no issue, `outValid` is 0 and `outData` is 0.
- R2: Opcode 0 (SAD) returns, zero-extended to 64 bits, the sum over the eight unsigned bytes `srcA[8i+7:8i]` and `srcB[8i+7:8i]` of their absolute differences. The largest value is 2040, which occupies bits 10:0. `srcC` and `srcD` have no effect.
- R3: Opcode 1 (rounding multiply) treats each 16-bit lane `[16j+15:16j]` of `srcA` and `srcB` as signed. It forms the full 32-bit product, adds 0x8000, and returns bits 31:16 of that sum in the same lane. For example, 0x8000 times 0x8000 gives 0x4000.
- R4: Opcode 2 (four-way average) returns in each byte lane `(a+b+c+d+2)>>2`, computed without overflow. Here a, b, c and d are the bytes of `srcA`, `srcB`, `srcC` and `srcD` in that lane.
- R5: An operation sampled at a clock edge with `inValid`=1 and `inGuard`=1 drives `outValid`=1 and its result on `outData` after the second following edge. Operations issued on consecutive cycles return on consecutive cycles, in order.
- R6: An operation with `inGuard`=0 produces no `outValid` pulse, and `outData` keeps its previous value.
- R7: Opcode 3 is reserved and is treated like a false guard: no `outValid` pulse, and `outData` is unchanged.
- R8: A cycle with `inValid`=0 produces no `outValid` pulse and leaves `outData` unchanged, whatever the operand and opcode inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Issue strobe |
| inOp | input | 2 | Opcode: 0 SAD, 1 rounding multiply, 2 four-way average, 3 reserved |
| inGuard | input | 1 | Predicate; the result is written only when it is 1 |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| srcC | input | 64 | Third operand (average only) |
| srcD | input | 64 | Fourth operand (average only) |
| outValid | output | 1 | Result strobe |
| outData | output | 64 | Result register |

## Verification
The SAD is driven with all-ones against all-zeros. A design that truncates the lane sum to a byte, or that sign-extends it, returns a value other than 2040. The multiply is driven with the most negative operand on both inputs and with pairs just on either side of the rounding point. A design that truncates instead of rounding, or that takes the wrong half of the product, misses by one or returns a swapped lane. The average is driven with all-ones inputs and with sums that sit exactly on the rounding boundary, which catches a narrow intermediate that wraps or a missing round constant. A false guard, the reserved opcode and an idle cycle each follow a known write, and a unit that wrongly writes on any of them shows a spurious strobe or changed data.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    OP_SAD  = 2'd0,
    OP_MULR = 2'd1,
    OP_AVG4 = 2'd2,
    OP_RSV  = 2'd3
  } opcode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    s1Capture;
    logic    s2Write;
    opcode_t s2Op;
  } ctrl_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inOp,
  input  logic       inGuard,
  output ctrl_t      ctrl,
  output logic       outValid
);

  opcode_t opIn;
  logic    issue;
  logic    s1Valid;
  opcode_t s1Op;
  logic    outValidR;

  assign opIn  = opcode_t'(inOp);
  assign issue = inValid && inGuard && (opIn != OP_RSV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1Op      <= OP_SAD;
      outValidR <= 1'b0;
    end else begin
      s1Valid   <= issue;
      s1Op      <= opIn;
      outValidR <= s1Valid;
    end
  end

  assign ctrl.s1Capture = issue;
  assign ctrl.s2Write   = s1Valid;
  assign ctrl.s2Op      = s1Op;
  assign outValid       = outValidR;

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> ##2 outValid);

  // R6
  squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inGuard) |-> ##2 !outValid);

  // R7
  reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opIn == OP_RSV) |-> ##2 !outValid);

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [DATA_W-1:0] srcD,
  output logic [DATA_W-1:0] outData
);

  localparam int LANE8  = DATA_W / 8;
  localparam int LANE16 = DATA_W / 16;
  localparam int SAD_W  = $clog2(LANE8 * 255 + 1);

  logic [7:0]         absR  [LANE8];
  logic [9:0]         sumR  [LANE8];
  logic signed [31:0] prodR [LANE16];
  logic [7:0]         avgLane [LANE8];
  logic [15:0]        mulLane [LANE16];
  logic [DATA_W-1:0]  avgVec, mulVec, resNext;
  logic [SAD_W-1:0]   sadSum;

  // stage 1: per-lane differences, sums and products
  for (genvar i = 0; i < LANE8; i++) begin : g_byte
    logic [7:0] a8, b8;
    assign a8 = srcA[8*i +: 8];
    assign b8 = srcB[8*i +: 8];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        absR[i] <= '0;
        sumR[i] <= '0;
      end else if (ctrl.s1Capture) begin
        absR[i] <= (a8 > b8) ? (a8 - b8) : (b8 - a8);
        sumR[i] <= 10'(a8) + 10'(b8) + 10'(srcC[8*i +: 8]) + 10'(srcD[8*i +: 8]);
      end
    end
    logic [9:0] sumRnd;
    assign sumRnd     = sumR[i] + 10'd2;
    assign avgLane[i] = sumRnd[9:2];
    assign avgVec[8*i +: 8] = avgLane[i];
  end

  for (genvar j = 0; j < LANE16; j++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN) prodR[j] <= '0;
      else if (ctrl.s1Capture)
        prodR[j] <= $signed(srcA[16*j +: 16]) * $signed(srcB[16*j +: 16]);
    end
    logic signed [32:0] prodRnd;
    assign prodRnd    = {prodR[j][31], prodR[j]} + 33'sh8000;
    assign mulLane[j] = prodRnd[31:16];
    assign mulVec[16*j +: 16] = mulLane[j];
  end

  // stage 2: reduction and result selection
  always_comb begin
    sadSum = '0;
    for (int i = 0; i < LANE8; i++) sadSum = sadSum + SAD_W'(absR[i]);
  end

  always_comb begin
    unique case (ctrl.s2Op)
      OP_MULR: resNext = mulVec;
      OP_AVG4: resNext = avgVec;
      default: resNext = DATA_W'(sadSum);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outData <= '0;
    else if (ctrl.s2Write) outData <= resNext;
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.s2Write |=> $stable(outData));

  // R2
  sad_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.s2Write && ctrl.s2Op == OP_SAD) |=> (outData[DATA_W-1:SAD_W] == '0));

endmodule

// File: rtl/simd_media_unit.sv
module simd_media_unit
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inOp,
  input  logic              inGuard,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcC,
  input  logic [DATA_W-1:0] srcD,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  ctrl_t ctrl;

  simd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .inGuard(inGuard), .ctrl(ctrl), .outValid(outValid)
  );

  simd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .srcC(srcC), .srcD(srcD), .outData(outData)
  );

endmodule

// File: tb/tb_simd_media_unit.sv
module tb_simd_media_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {op, a, b, c, d}
  localparam logic [257:0] VEC [NVEC] = '{
    {2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F},
    {2'd0, 64'h0011_2233_4455_6677, 64'h7766_5544_3322_1100, 64'hFFFF_0000_FFFF_0000, 64'h0},
    {2'd0, 64'hA5A5_A5A5_A5A5_A5A5, 64'hA5A5_A5A5_A5A5_A5A5, 64'h0, 64'h0},
    {2'd1, 64'h8000_8000_7FFF_7FFF, 64'h8000_7FFF_7FFF_8000, 64'h0, 64'h0},
    {2'd1, 64'h0001_FFFF_0100_0003, 64'h8000_8000_0080_5555, 64'hDEAD_BEEF_0000_0000, 64'h0},
    {2'd1, 64'h1234_CDEF_0000_7FFF, 64'h5678_4321_FFFF_0001, 64'h0, 64'h0},
    {2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd2, 64'h0101_0100_0001_0000, 64'h0101_0000_0001_0000, 64'h0100_0000_0000_0000, 64'h0000_0000_0000_0000},
    {2'd2, 64'h0102_0304_FF80_7F00, 64'h0203_0405_FF80_8001, 64'h0304_0506_0080_7F02, 64'h0405_0607_0000_8003},
    {2'd0, 64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, 64'h0, 64'h0}
  };

  logic clk = 1'b0;
  logic rstN, inValid, inGuard;
  logic [1:0] inOp;
  logic [63:0] srcA, srcB, srcC, srcD;
  logic outValid;
  logic [63:0] outData;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_media_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inGuard(inGuard),
    .srcA(srcA), .srcB(srcB), .srcC(srcC), .srcD(srcD),
    .outValid(outValid), .outData(outData)
  );

  function automatic logic [63:0] refModel(logic [1:0] op, logic [63:0] a, b, c, d);
    logic [63:0] r = '0;
    int s = 0;
    case (op)
      2'd0: begin
        for (int i = 0; i < 8; i++) begin
          int x = int'(a[8*i +: 8]);
          int y = int'(b[8*i +: 8]);
          s += (x > y) ? x - y : y - x;
        end
        r = 64'(s);
      end
      2'd1: begin
        for (int j = 0; j < 4; j++) begin
          longint p = longint'($signed(a[16*j +: 16])) * longint'($signed(b[16*j +: 16]));
          longint q = (p + 64'sd32768) >>> 16;
          r[16*j +: 16] = q[15:0];
        end
      end
      2'd2: begin
        for (int i = 0; i < 8; i++) begin
          int t = int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + int'(c[8*i +: 8]) + int'(d[8*i +: 8]) + 2;
          r[8*i +: 8] = 8'(t >> 2);
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic g, logic [1:0] op, logic [63:0] a, b, c, d);
    inValid = v; inGuard = g; inOp = op;
    srcA = a; srcB = b; srcC = c; srcD = d;
  endtask

  // issue one op, then idle, sample after the second edge
  task automatic runOne(logic v, logic g, logic [1:0] op, logic [63:0] a, b, c, d);
    @(negedge clk); drive(v, g, op, a, b, c, d);
    @(negedge clk); drive(1'b0, 1'b1, 2'd0, '0, '0, '0, '0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rstN = 1'b0;
    drive(1'b0, 1'b0, 2'd0, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 outValid in reset", {63'd0, outValid}, 64'd0);
    check("R1 outData in reset", outData, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 outValid after release", {63'd0, outValid}, 64'd0);

    // R2 R3 R4 vector walk
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] op = VEC[k][257:256];
      logic [63:0] a = VEC[k][255:192], b = VEC[k][191:128];
      logic [63:0] c = VEC[k][127:64],  d = VEC[k][63:0];
      string req = (op == 2'd0) ? "R2 sad" : (op == 2'd1) ? "R3 mulr" : "R4 avg4";
      runOne(1'b1, 1'b1, op, a, b, c, d);
      check({req, " valid"}, {63'd0, outValid}, 64'd1);
      check(req, outData, refModel(op, a, b, c, d));
    end

    // R2 boundary: maximum SAD is 2040
    runOne(1'b1, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h0);
    check("R2 max", outData, 64'd2040);
    // R3 boundary: most negative squared
    runOne(1'b1, 1'b1, 2'd1, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h0);
    check("R3 min squared", outData, {4{16'h4000}});

    // R5 back-to-back issue
    @(negedge clk); drive(1'b1, 1'b1, 2'd0, VEC[1][255:192], VEC[1][191:128], 64'h0, 64'h0);
    @(negedge clk); drive(1'b1, 1'b1, 2'd1, VEC[3][255:192], VEC[3][191:128], 64'h0, 64'h0);
    @(negedge clk); drive(1'b1, 1'b1, 2'd2, VEC[8][255:192], VEC[8][191:128], VEC[8][127:64], VEC[8][63:0]);
    check("R5 first", outData, refModel(2'd0, VEC[1][255:192], VEC[1][191:128], 64'h0, 64'h0));
    @(negedge clk); drive(1'b0, 1'b1, 2'd0, '0, '0, '0, '0);
    check("R5 second", outData, refModel(2'd1, VEC[3][255:192], VEC[3][191:128], 64'h0, 64'h0));
    @(negedge clk);
    check("R5 third valid", {63'd0, outValid}, 64'd1);
    check("R5 third", outData, refModel(2'd2, VEC[8][255:192], VEC[8][191:128], VEC[8][127:64], VEC[8][63:0]));
    @(negedge clk);
    check("R5 strobe drops", {63'd0, outValid}, 64'd0);

    // R6 guard false
    runOne(1'b1, 1'b1, 2'd0, 64'h0102_0304_0506_0708, 64'h0, 64'h0, 64'h0);
    held = outData;
    check("R6 setup", held, 64'd36);
    runOne(1'b1, 1'b0, 2'd2, {8{8'hFF}}, {8{8'hFF}}, {8{8'hFF}}, {8{8'hFF}});
    check("R6 no strobe", {63'd0, outValid}, 64'd0);
    check("R6 data held", outData, held);

    // R7 reserved opcode
    runOne(1'b1, 1'b1, 2'd3, {8{8'hFF}}, 64'h0, 64'h0, 64'h0);
    check("R7 no strobe", {63'd0, outValid}, 64'd0);
    check("R7 data held", outData, held);

    // R8 idle cycle with busy operands
    runOne(1'b0, 1'b1, 2'd1, {4{16'h7FFF}}, {4{16'h7FFF}}, 64'h0, 64'h0);
    check("R8 no strobe", {63'd0, outValid}, 64'd0);
    check("R8 data held", outData, held);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule